// File: doc/BRIEF.md
# Floating-point load/store decode and trap unit

This unit sits in the decode stage of a processor pipeline. It inspects one 32-bit instruction word per valid cycle and decides whether it is a floating-point memory transfer. When it is, the unit reports how wide the transfer is and which way data moves. It also gives the integer source operands and the floating-point register the transfer names, translated into the even-aligned wide-register index space. Finally it says whether the transfer may go ahead or which exception must be taken instead.

The unit looks at four side conditions: the current privilege level, whether the FPU is switched on, whether 128-bit precision is implemented, and which of two architecture variants is running. On the 32-bit variant, one store encoding is reused as the privileged store of the floating-point queue. That store never touches memory; it ends in a privileged-instruction, FP-disabled or sequence-error exception, checked in that order. Every result appears one clock after the instruction is presented, framed by a valid flag.

Top module: `fpx_decode_unit`

## Requirements
- R1: Every output is registered. `outValid` equals `inValid` of the previous cycle. While `outValid` is low, `excCode`, `memGo` and `markDirty` are all zero. A synchronous `rst` clears `outValid`, `excCode`, `memGo` and `markDirty` at the next edge.
- R2: `hit` is 1 exactly when `instr[31:30]` is 2'b11 and the op3 field `instr[24:19]` lies in 0x20..0x27. For any other instruction, `excCode` is zero and `memGo` is 0.
- R3: Op3 decodes as follows: 0x20 is a 32-bit load, 0x23 a 64-bit load, 0x22 a 128-bit load, 0x24 a 32-bit store, 0x27 a 64-bit store and 0x26 a 128-bit store. `accSize` encodes 0 for 32 bits, 1 for 64 bits and 2 for 128 bits. `isStore` is 1 for the three stores.
- R4: `useImm` equals `instr[13]`. `immVal` is `instr[12:0]` sign-extended to XLEN bits. `rs1Idx` is `instr[18:14]` and `rs2Idx` is `instr[4:0]`.
- R5: With rd = `instr[29:25]`, the 6-bit `fpRegIdx` is formed by access size:
  - 32-bit: {0, rd}
  - 64-bit: {rd[0], rd[4:1], 0}
  - 128-bit: {rd[0], rd[4:2], 00}
- R6: Op3 0x21 and 0x25 raise the illegal-instruction exception (`excCode` bit 0), whatever the other flags are.
- R7: A legal non-queue transfer with `fpuOn` low raises FP-disabled (`excCode` bit 2) and does not assert `memGo`.
- R8: A 128-bit transfer with `fpuOn` high and `hasQuad` low raises unimplemented-FPop (`excCode` bit 3). If `fpuOn` is also low, R7 takes precedence.
- R9: With `is32bVariant` high, op3 0x26 is the queue store and is checked in this order:
  - `isPriv` low: privileged-instruction (bit 1)
  - otherwise `fpuOn` low: FP-disabled (bit 2)
  - otherwise: sequence error (bit 4)
  
  `memGo` stays low in every case, whatever `hasQuad` is.
- R10: A transfer that raises no exception sets `memGo`. `markDirty` is 1 only for such a transfer when it is a load.
- R11: For every instruction with `hit` high, exactly one of the five `excCode` bits and `memGo` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| isPriv | input | 1 | Supervisor mode |
| fpuOn | input | 1 | FPU enabled |
| hasQuad | input | 1 | 128-bit precision implemented |
| is32bVariant | input | 1 | 32-bit architecture variant selected |
| outValid | output | 1 | Registered results are valid |
| hit | output | 1 | Instruction is an FP load/store-range op |
| accSize | output | 2 | Access size: 0=32, 1=64, 2=128 bits |
| isStore | output | 1 | Transfer direction is store |
| useImm | output | 1 | Second operand is the immediate |
| rs1Idx | output | 5 | First source register index |
| rs2Idx | output | 5 | Second source register index |
| immVal | output | XLEN | Sign-extended immediate |
| fpRegIdx | output | 6 | Remapped FP register index |
| memGo | output | 1 | Memory access may be issued |
| markDirty | output | 1 | Destination FP register becomes dirty |
| excCode | output | 5 | One-hot exception: 0 illegal, 1 privileged, 2 FP disabled, 3 unimplemented FPop, 4 sequence error |

## Verification
The bench builds the unit with the default XLEN of 32. It sweeps every combination of the eight op3 values in the range, the four side flags and all 32 rd values. This covers each path through the priority chain and every remap case, including the queue store on both variants. Immediate sign-boundary values, out-of-range encodings and a reset applied while input is valid fill in the edges that the sweep leaves out.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int INSN_W = 32;
  localparam int OP3_W  = 6;
  localparam int REG_W  = 5;
  localparam int IDX_W  = REG_W + 1;
  localparam int IMM_W  = 13;
  localparam int EXC_N  = 5;

  // one-hot exception bit positions
  localparam int EXC_ILL   = 0;
  localparam int EXC_PRIV  = 1;
  localparam int EXC_FPOFF = 2;
  localparam int EXC_UNIMP = 3;
  localparam int EXC_SEQ   = 4;

  typedef enum logic [1:0] {
    SZ_WORD = 2'd0,
    SZ_DBL  = 2'd1,
    SZ_QUAD = 2'd2
  } size_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic  capture;
    size_e remap;
  } dpStrobe_t;
endpackage

// File: rtl/fpx_control.sv
module fpx_control
  import fpx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic [1:0]           instrOp,
  input  logic [OP3_W-1:0]     op3,
  input  logic                 isPriv,
  input  logic                 fpuOn,
  input  logic                 hasQuad,
  input  logic                 is32bVariant,
  output dpStrobe_t            dpCtl,
  output logic                 outValid,
  output logic                 hit,
  output size_e                accSize,
  output logic                 isStore,
  output logic                 memGo,
  output logic                 markDirty,
  output logic [EXC_N-1:0]     excCode
);

  logic             inRange;
  logic             storeC;
  logic             illegalC;
  logic             queueC;
  logic             goC;
  size_e            sizeC;
  logic [EXC_N-1:0] excC;

  always_comb begin
    inRange  = (instrOp == 2'b11) && (op3[5:3] == 3'b100);
    storeC   = op3[2];
    illegalC = (op3[1:0] == 2'b01);
    case (op3[1:0])
      2'b10:   sizeC = SZ_QUAD;
      2'b11:   sizeC = SZ_DBL;
      default: sizeC = SZ_WORD;
    endcase
    queueC = is32bVariant && storeC && (op3[1:0] == 2'b10);

    excC = '0;
    goC  = 1'b0;
    if (inRange) begin
      if (illegalC) begin
        excC[EXC_ILL] = 1'b1;
      end else if (queueC) begin
        if (!isPriv)     excC[EXC_PRIV]  = 1'b1;
        else if (!fpuOn) excC[EXC_FPOFF] = 1'b1;
        else             excC[EXC_SEQ]   = 1'b1;
      end else if (!fpuOn) begin
        excC[EXC_FPOFF] = 1'b1;
      end else if (sizeC == SZ_QUAD && !hasQuad) begin
        excC[EXC_UNIMP] = 1'b1;
      end else begin
        goC = 1'b1;
      end
    end
  end

  assign dpCtl.capture = inValid;
  assign dpCtl.remap   = sizeC;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      excCode   <= '0;
      memGo     <= 1'b0;
      markDirty <= 1'b0;
      hit       <= 1'b0;
      accSize   <= SZ_WORD;
      isStore   <= 1'b0;
    end else begin
      outValid  <= inValid;
      excCode   <= inValid ? excC : '0;
      memGo     <= inValid & goC;
      markDirty <= inValid & goC & ~storeC;
      if (inValid) begin
        hit     <= inRange;
        accSize <= sizeC;
        isStore <= storeC;
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid); // R1
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> (excCode == '0 && !memGo && !markDirty)); // R1
  AST_MISS_SILENT: assert property (@(posedge clk) disable iff (rst)
    (outValid && !hit) |-> (excCode == '0 && !memGo)); // R2
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    (outValid && hit) |-> ($countones({excCode, memGo}) == 1)); // R11
  AST_DIRTY_LOADS: assert property (@(posedge clk) disable iff (rst)
    markDirty |-> (memGo && !isStore)); // R10
  AST_SEQ_QUEUE_ONLY: assert property (@(posedge clk) disable iff (rst)
    excCode[EXC_SEQ] |-> (isStore && accSize == SZ_QUAD)); // R9

endmodule

// File: rtl/fpx_datapath.sv
module fpx_datapath
  import fpx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         dpCtl,
  input  logic [REG_W-1:0]  rdField,
  input  logic [REG_W-1:0]  rs1Field,
  input  logic [REG_W-1:0]  rs2Field,
  input  logic              immBit,
  input  logic [IMM_W-1:0]  immField,
  output logic [REG_W-1:0]  rs1Idx,
  output logic [REG_W-1:0]  rs2Idx,
  output logic              useImm,
  output logic [XLEN-1:0]   immVal,
  output logic [IDX_W-1:0]  fpRegIdx
);

  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0]  immExt;
  logic [IDX_W-1:0] idxWord;
  logic [IDX_W-1:0] idxDbl;
  logic [IDX_W-1:0] idxQuad;
  logic [IDX_W-1:0] idxSel;

  assign immExt  = {{EXT_W{immField[IMM_W-1]}}, immField};
  assign idxWord = {1'b0, rdField};
  assign idxDbl  = {rdField[0], rdField[REG_W-1:1], 1'b0};
  assign idxQuad = {rdField[0], rdField[REG_W-1:2], 2'b00};

  always_comb begin
    case (dpCtl.remap)
      SZ_DBL:  idxSel = idxDbl;
      SZ_QUAD: idxSel = idxQuad;
      default: idxSel = idxWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rs1Idx   <= '0;
      rs2Idx   <= '0;
      useImm   <= 1'b0;
      immVal   <= '0;
      fpRegIdx <= '0;
    end else if (dpCtl.capture) begin
      rs1Idx   <= rs1Field;
      rs2Idx   <= rs2Field;
      useImm   <= immBit;
      immVal   <= immExt;
      fpRegIdx <= idxSel;
    end
  end

  AST_IMM_SIGN: assert property (@(posedge clk) disable iff (rst)
    ((&immVal[XLEN-1:IMM_W-1]) || !(|immVal[XLEN-1:IMM_W-1]))); // R4
  AST_IMM_RS2_LINK: assert property (@(posedge clk) disable iff (rst)
    (immVal[REG_W-1:0] == rs2Idx)); // R4

endmodule

// File: rtl/fpx_decode_unit.sv
module fpx_decode_unit
  import fpx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [31:0]       instr,
  input  logic              isPriv,
  input  logic              fpuOn,
  input  logic              hasQuad,
  input  logic              is32bVariant,
  output logic              outValid,
  output logic              hit,
  output logic [1:0]        accSize,
  output logic              isStore,
  output logic              useImm,
  output logic [4:0]        rs1Idx,
  output logic [4:0]        rs2Idx,
  output logic [XLEN-1:0]   immVal,
  output logic [5:0]        fpRegIdx,
  output logic              memGo,
  output logic              markDirty,
  output logic [4:0]        excCode
);

  dpStrobe_t dpCtl;
  size_e     accSizeE;

  fpx_control u_control (
    .clk          (clk),
    .rst          (rst),
    .inValid      (inValid),
    .instrOp      (instr[31:30]),
    .op3          (instr[24:19]),
    .isPriv       (isPriv),
    .fpuOn        (fpuOn),
    .hasQuad      (hasQuad),
    .is32bVariant (is32bVariant),
    .dpCtl        (dpCtl),
    .outValid     (outValid),
    .hit          (hit),
    .accSize      (accSizeE),
    .isStore      (isStore),
    .memGo        (memGo),
    .markDirty    (markDirty),
    .excCode      (excCode)
  );

  fpx_datapath #(.XLEN(XLEN)) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .dpCtl    (dpCtl),
    .rdField  (instr[29:25]),
    .rs1Field (instr[18:14]),
    .rs2Field (instr[4:0]),
    .immBit   (instr[13]),
    .immField (instr[12:0]),
    .rs1Idx   (rs1Idx),
    .rs2Idx   (rs2Idx),
    .useImm   (useImm),
    .immVal   (immVal),
    .fpRegIdx (fpRegIdx)
  );

  assign accSize = accSizeE;

  AST_DBL_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (outValid && hit && accSize == 2'd1) |-> (fpRegIdx[0] == 1'b0)); // R5
  AST_QUAD_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (outValid && hit && accSize == 2'd2) |-> (fpRegIdx[1:0] == 2'b00)); // R5

endmodule

// File: tb/fpx_decode_unit_bench.sv
module fpx_decode_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int WATCHDOG = 20000;

  logic            clk = 1'b0;
  logic            rst;
  logic            inValid;
  logic [31:0]     instr;
  logic            isPriv, fpuOn, hasQuad, is32bVariant;
  logic            outValid, hit, isStore, useImm, memGo, markDirty;
  logic [1:0]      accSize;
  logic [4:0]      rs1Idx, rs2Idx, excCode;
  logic [XLEN-1:0] immVal;
  logic [5:0]      fpRegIdx;

  int nChk = 0;
  int nBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpx_decode_unit #(.XLEN(XLEN)) u_fpx_decode_unit (
    .clk(clk), .rst(rst), .inValid(inValid), .instr(instr),
    .isPriv(isPriv), .fpuOn(fpuOn), .hasQuad(hasQuad), .is32bVariant(is32bVariant),
    .outValid(outValid), .hit(hit), .accSize(accSize), .isStore(isStore),
    .useImm(useImm), .rs1Idx(rs1Idx), .rs2Idx(rs2Idx), .immVal(immVal),
    .fpRegIdx(fpRegIdx), .memGo(memGo), .markDirty(markDirty), .excCode(excCode)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkInstr(input logic [1:0] op, input logic [4:0] rd,
      input logic [5:0] op3, input logic [4:0] rs1, input logic ib, input logic [12:0] imm);
    return {op, rd, op3, rs1, ib, imm};
  endfunction

  // expected outcome from the priority rules
  task automatic model(input int lo, input logic priv, input logic fpu, input logic quad,
                       input logic v32, output logic [4:0] exc, output logic go,
                       output string req);
    exc = '0; go = 1'b0;
    if (lo == 1 || lo == 5) begin exc[0] = 1'b1; req = "R6"; end
    else if (v32 && lo == 6) begin
      req = "R9";
      if (!priv) exc[1] = 1'b1;
      else if (!fpu) exc[2] = 1'b1;
      else exc[4] = 1'b1;
    end else if (!fpu) begin exc[2] = 1'b1; req = "R7"; end
    else if ((lo == 2 || lo == 6) && !quad) begin exc[3] = 1'b1; req = "R8"; end
    else begin go = 1'b1; req = "R10"; end
  endtask

  function automatic logic [31:0] sext13(input logic [12:0] v);
    int u;
    u = int'(v);
    if (u >= 4096) u = u - 8192;
    return 32'(u);
  endfunction

  task automatic checkMiss(input logic [31:0] w, input string tag);
    instr = w; inValid = 1'b1;
    @(negedge clk);
    chk("R2", {tag, " hit"}, 64'(hit), 64'd0);
    chk("R2", {tag, " exc"}, 64'(excCode), 64'd0);
    chk("R2", {tag, " go"}, 64'(memGo), 64'd0);
    chk("R1", {tag, " valid"}, 64'(outValid), 64'd1);
  endtask

  initial begin
    rst = 1'b1; inValid = 1'b1; isPriv = 1'b0; fpuOn = 1'b0; hasQuad = 1'b0;
    is32bVariant = 1'b0;
    instr = mkInstr(2'b11, 5'd0, 6'h21, 5'd0, 1'b0, 13'd0);
    @(negedge clk);
    @(negedge clk);
    chk("R1", "reset valid", 64'(outValid), 64'd0);
    chk("R1", "reset exc", 64'(excCode), 64'd0);
    chk("R1", "reset go", 64'(memGo), 64'd0);
    chk("R1", "reset dirty", 64'(markDirty), 64'd0);
    rst = 1'b0;

    // exhaustive sweep: op3 low bits x flags x rd
    for (int lo = 0; lo < 8; lo++) begin
      for (int fl = 0; fl < 16; fl++) begin
        for (int rd = 0; rd < 32; rd++) begin
          logic [12:0] imm;
          logic [4:0]  expExc;
          logic        expGo;
          string       req;
          int          expIdx;
          imm = 13'(rd * 263 + fl * 517 + lo * 1031);
          isPriv = fl[0]; fpuOn = fl[1]; hasQuad = fl[2]; is32bVariant = fl[3];
          instr = mkInstr(2'b11, 5'(rd), {3'b100, 3'(lo)}, 5'(rd) ^ 5'h1f,
                          rd[0], imm);
          inValid = 1'b1;
          @(negedge clk);
          model(lo, fl[0], fl[1], fl[2], fl[3], expExc, expGo, req);
          chk("R1", "valid", 64'(outValid), 64'd1);
          chk("R2", "hit", 64'(hit), 64'd1);
          chk(req, "excCode", 64'(excCode), 64'(expExc));
          chk(req, "memGo", 64'(memGo), 64'(expGo));
          chk("R10", "markDirty", 64'(markDirty), 64'(expGo && lo < 4));
          chk("R11", "one outcome", 64'($countones({excCode, memGo})), 64'd1);
          chk("R4", "useImm", 64'(useImm), 64'(rd % 2));
          chk("R4", "rs1Idx", 64'(rs1Idx), 64'(31 - rd));
          chk("R4", "rs2Idx", 64'(rs2Idx), 64'(imm[4:0]));
          chk("R4", "immVal", 64'(immVal), 64'(sext13(imm)));
          if (lo != 1 && lo != 5) begin
            int expSz;
            expSz = (lo == 2 || lo == 6) ? 2 : ((lo == 3 || lo == 7) ? 1 : 0);
            chk("R3", "accSize", 64'(accSize), 64'(expSz));
            chk("R3", "isStore", 64'(isStore), 64'(lo >= 4));
            if (expSz == 0) expIdx = rd;
            else if (expSz == 1) expIdx = (rd & 30) + (rd & 1) * 32;
            else expIdx = (rd & 28) + (rd & 1) * 32;
            chk("R5", "fpRegIdx", 64'(fpRegIdx), 64'(expIdx));
          end
        end
      end
    end

    // immediate sign boundaries
    isPriv = 1'b1; fpuOn = 1'b1; hasQuad = 1'b1; is32bVariant = 1'b0;
    foreach (immList[i]) begin
      instr = mkInstr(2'b11, 5'd4, 6'h20, 5'd9, 1'b1, immList[i]);
      inValid = 1'b1;
      @(negedge clk);
      chk("R4", "imm boundary", 64'(immVal), 64'(sext13(immList[i])));
      chk("R4", "imm select", 64'(useImm), 64'd1);
    end

    // encodings outside the range
    checkMiss(mkInstr(2'b10, 5'd3, 6'h20, 5'd1, 1'b0, 13'd5), "op=10");
    checkMiss(mkInstr(2'b11, 5'd3, 6'h00, 5'd1, 1'b0, 13'd5), "op3=00");
    checkMiss(mkInstr(2'b11, 5'd3, 6'h30, 5'd1, 1'b0, 13'd5), "op3=30");
    checkMiss(mkInstr(2'b11, 5'd3, 6'h28, 5'd1, 1'b0, 13'd5), "op3=28");

    // idle cycle
    fpuOn = 1'b0;
    instr = mkInstr(2'b11, 5'd3, 6'h20, 5'd1, 1'b0, 13'd5);
    inValid = 1'b0;
    @(negedge clk);
    chk("R1", "idle valid", 64'(outValid), 64'd0);
    chk("R1", "idle exc", 64'(excCode), 64'd0);

    // reset while valid input carries a trapping op
    inValid = 1'b1;
    @(negedge clk);
    chk("R7", "pre-reset exc", 64'(excCode), 64'h4);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "mid reset valid", 64'(outValid), 64'd0);
    chk("R1", "mid reset exc", 64'(excCode), 64'd0);
    rst = 1'b0; inValid = 1'b0;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  logic [12:0] immList [4] = '{13'h0000, 13'h0FFF, 13'h1000, 13'h1FFF};

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule